// File: doc/BRIEF.md
# Pulse-Width Serial Word Decoder

This block recovers 10-bit words from a slow serial line on which each bit is a single pulse whose duration, not its level at a sampling instant, carries the value. A long pulse of roughly 81 ms means zero, and a short one of roughly 27 ms means one. The words arrive one per fixed 4-second window, with no start or stop bits.

The line is synchronised and its polarity is normalised by a parameter. A divider then produces a 1 ms tick, and each pulse is timed in ticks. Pulses that are too short are treated as glitches and ignored. Pulses that run too long raise an error. All other pulses are classified against a midpoint threshold and shifted into a word, most significant bit first. The finished word is announced with a one-cycle strobe. If a window closes before a word completes, a one-cycle frame error is raised instead.

Top module: `pulse_word_decoder`

## Requirements
- R1: The line passes through a two-flop synchroniser. A pulse is the time the line spends at its active level, which is high when ACTIVE_HIGH is 1 and low when it is 0.
- R2: Pulse length is measured in ticks, and one tick lasts CLK_DIV clock cycles.
- R3: A pulse shorter than GLITCH_TICKS ticks (10) changes no bit, no word and no flag.
- R4: A pulse of at least GLITCH_TICKS and at most LONG_TICKS ticks is a bit. The bit is 1 when the length is below SPLIT_TICKS (54) and 0 when it is at or above that value.
- R5: When a pulse passes LONG_TICKS ticks (150), pulse_err is high for exactly one cycle and the bits gathered so far are dropped. The pulse itself yields no bit.
- R6: Bits enter word MSB first, so the first bit of a window ends up in word[9]. On the 10th accepted bit, word_valid is high for exactly one cycle, within 4 clock cycles of that pulse's trailing edge, and word holds the 10 bits.
- R7: A window opens at the leading edge of a pulse seen while no window is open, and it lasts WINDOW_TICKS ticks (4000). Pulses that end while no window is open yield no bit.
- R8: If a window closes without a completed word, frame_err is high for exactly one cycle and the partial bits are discarded. word_valid and frame_err are never high together.
- R9: After a word completes, further pulses in the same window produce no word and no flag.
- R10: After reset, word_valid, pulse_err and frame_err are low and word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Asynchronous serial line |
| word | output | 10 | Last decoded word, MSB is the first bit received |
| word_valid | output | 1 | One-cycle strobe marking a new word |
| pulse_err | output | 1 | One-cycle flag for a pulse longer than the limit |
| frame_err | output | 1 | One-cycle flag for a window that closed without a word |

## Verification
A wrong threshold or a wrong pulse count shows up on the first decoded word, as flipped bits in word. It appears no more than a few cycles after the tenth trailing edge. A fault in the bit counter or in the window logic shows up in one of three ways: word_valid arrives after too few or too many pulses, frame_err appears when it should not, or frame_err fails to appear. Each of these shows within one window length. Extra pulses after a finished word, and pulses that are too short or too long, each reveal faulty state through an unexpected strobe or flag.

// File: rtl/pulse_word_decoder.sv
module pulse_word_decoder #(
  parameter int CLK_DIV      = 50000,
  parameter bit ACTIVE_HIGH  = 1'b1,
  parameter int GLITCH_TICKS = 10,
  parameter int SPLIT_TICKS  = 54,
  parameter int LONG_TICKS   = 150,
  parameter int WINDOW_TICKS = 4000,
  parameter int WORD_BITS    = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_in,
  output logic [WORD_BITS-1:0] word,
  output logic                 word_valid,
  output logic                 pulse_err,
  output logic                 frame_err
);
  localparam int DW = $clog2(CLK_DIV + 1);
  localparam int PW = $clog2(LONG_TICKS + 2);
  localparam int WW = $clog2(WINDOW_TICKS + 1);
  localparam int BW = $clog2(WORD_BITS + 1);
  localparam logic IDLE_LVL = ~ACTIVE_HIGH;

  logic [2:0]    sh;
  logic [DW-1:0] div;
  logic [PW-1:0] pcnt;
  logic [WW-1:0] wcnt;
  logic [BW-1:0] bits;
  logic          win_open, done;

  wire act      = sh[1] ^ IDLE_LVL;
  wire act_q    = sh[2] ^ IDLE_LVL;
  wire lead     = act & ~act_q;
  wire trail    = ~act & act_q;
  wire tick     = (div == DW'(CLK_DIV - 1));
  wire len_ok   = (pcnt >= PW'(GLITCH_TICKS)) && (pcnt <= PW'(LONG_TICKS));
  wire accept   = trail & win_open & ~done & len_ok;
  wire complete = accept && (bits == BW'(WORD_BITS - 1));
  wire overrun  = act & ~lead & tick & (pcnt == PW'(LONG_TICKS));
  wire closing  = win_open & tick & (wcnt == WW'(WINDOW_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh  <= {3{IDLE_LVL}};
      div <= '0;
    end else begin
      sh  <= {sh[1:0], line_in};
      div <= tick ? '0 : div + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      pcnt <= '0;
    else if (lead)
      pcnt <= '0;
    else if (act && tick && pcnt <= PW'(LONG_TICKS))
      pcnt <= pcnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      win_open   <= 1'b0;
      wcnt       <= '0;
      bits       <= '0;
      done       <= 1'b0;
      word       <= '0;
      word_valid <= 1'b0;
      pulse_err  <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      word_valid <= complete;
      pulse_err  <= overrun;
      frame_err  <= closing & ~done & ~complete;
      if (lead && !win_open) begin
        win_open <= 1'b1;
        wcnt     <= '0;
        bits     <= '0;
        done     <= 1'b0;
      end else begin
        if (closing)
          win_open <= 1'b0;
        else if (win_open && tick)
          wcnt <= wcnt + 1'b1;
        if (overrun)
          bits <= '0;
        else if (accept) begin
          word <= {word[WORD_BITS-2:0], pcnt < PW'(SPLIT_TICKS)};
          bits <= complete ? '0 : bits + 1'b1;
          done <= complete;
        end
      end
    end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R6
  AST_PERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_err |=> !pulse_err); // R5
  AST_PERR_DROPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_err |-> bits == '0); // R5
  AST_FERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err); // R8
  AST_NO_VALID_WITH_FERR: assert property (@(posedge clk) disable iff (!rst_n)
    !(word_valid && frame_err)); // R8
  AST_FERR_AT_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> !win_open); // R7
  AST_BITS_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    bits < BW'(WORD_BITS)); // R6
  AST_NO_WORD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done && $stable(done) |-> !word_valid); // R9
endmodule

// File: tb/test_pulse_word_decoder.sv
module test_pulse_word_decoder;
  localparam int DIV = 2;
  localparam int WIN = 4000;
  localparam int GAP = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_in = 1'b1;
  logic [9:0] word;
  logic       word_valid, pulse_err, frame_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int win_start = 0;
  logic [11:0] exp_q[$];
  string       req_q[$];

  pulse_word_decoder #(.CLK_DIV(DIV), .ACTIVE_HIGH(1'b0), .WINDOW_TICKS(WIN)) i_pulse_word_decoder (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .word(word),
    .word_valid(word_valid), .pulse_err(pulse_err), .frame_err(frame_err));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // kind in bits 11:10: 0 = word, 1 = frame error, 2 = pulse error
  task automatic expect_item(input logic [1:0] kind, input logic [9:0] w, input string req);
    exp_q.push_back({kind, w});
    req_q.push_back(req);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // active level is low (ACTIVE_HIGH = 0), R1
  task automatic pulse(input int ticks);
    line_in = 1'b0;
    repeat (ticks * DIV) @(negedge clk);
    line_in = 1'b1;
    repeat (GAP * DIV) @(negedge clk);
  endtask

  task automatic send_bits(input logic [9:0] w, input int n);
    for (int i = 9; i > 9 - n; i--) pulse(w[i] ? 27 : 81);
  endtask

  task automatic start_window;
    win_start = cyc;
  endtask

  task automatic end_window;
    while (cyc < win_start + WIN * DIV + 30) @(negedge clk);
  endtask

  task automatic full_word(input logic [9:0] w, input string req);
    start_window();
    expect_item(2'd0, w, req);
    send_bits(w, 10);
    end_window();
  endtask

  always @(negedge clk) begin
    if (rst_n && (word_valid || frame_err || pulse_err)) begin
      logic [11:0] got;
      got = {pulse_err ? 2'd2 : frame_err ? 2'd1 : 2'd0, word_valid ? word : 10'h0};
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected output R3 R9", 32'(got), 32'h0);
      end else begin
        logic [11:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        if (e[11:10] != 2'd0) e[9:0] = 10'h0;
        check(got == e, r, 32'(got), 32'(e));
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(word_valid == 1'b0, "R10 word_valid", 32'(word_valid), 0);
    check(pulse_err == 1'b0, "R10 pulse_err", 32'(pulse_err), 0);
    check(frame_err == 1'b0, "R10 frame_err", 32'(frame_err), 0);
    check(word == 10'h0, "R10 word", 32'(word), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    full_word(10'h2B5, "R4 R6 R1 R2 mixed word");
    full_word(10'h3FF, "R4 all ones");
    full_word(10'h000, "R4 all zeros");
    full_word(10'h201, "R6 msb first");

    // glitches between bits are ignored, R3
    start_window();
    expect_item(2'd0, 10'h156, "R3 glitches ignored");
    for (int i = 9; i >= 0; i--) begin
      pulse(4);
      pulse(10'h156 >> i & 1 ? 27 : 81);
    end
    end_window();

    // partial word then window close, R8
    start_window();
    expect_item(2'd1, 10'h0, "R8 frame error");
    send_bits(10'h3C0, 6);
    end_window();
    check(exp_q.size() == 0, "R8 frame error seen", exp_q.size(), 0);

    // over-long pulse drops bits, R5
    start_window();
    send_bits(10'h3FF, 3);
    expect_item(2'd2, 10'h0, "R5 pulse error");
    pulse(200);
    expect_item(2'd0, 10'h0CA, "R5 word after error");
    send_bits(10'h0CA, 10);
    end_window();

    // extra pulses after completed word, R9
    start_window();
    expect_item(2'd0, 10'h333, "R9 first word");
    send_bits(10'h333, 10);
    send_bits(10'h3FF, 3);
    end_window();
    check(exp_q.size() == 0, "R9 no extra output", exp_q.size(), 0);

    // new window accepted after close, R7
    full_word(10'h1E7, "R7 next window");

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R6 all words delivered", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule